// File: doc/BRIEF.md
# Fractional-N Feedback Divide Sequencer

This block runs on the crystal reference clock and produces, on every reference cycle, the integer ratio that the feedback divider of a fractional-N synthesizer should use next. It takes a 15-bit frequency word, an 8-bit separation word, a band-select bit, a modulation-type bit and the serial transmit data bit. From these it forms one exact fractional target, a numerator over 32768, and dithers between the two neighbouring integers with a first-order phase accumulator. Over time the average ratio equals the target exactly.

The target is `base*32768 + 2*(word + offset) + 1`. The base is 24 when the band bit is low and 32.5 when it is high. The trailing `+1` supplies a built-in half step of the frequency word. In two-level FSK the transmit bit chooses an offset of zero or the full separation word. In on-off keying mode the offset is fixed at half the separation word, rounded down, and the data bit does not move the carrier. The step size is the reference over 16384, and the FSK deviation is the separation word times the reference over 32768.

Top module: `fracn_div_seq`

## Requirements
- R1: With `band_hi`=0 the average ratio is 24 + (freq_word + offset + 0.5)/16384: integer part `(786432 + 2*(freq_word+offset) + 1) >> 15`, fraction the low 15 bits of that sum.
- R2: With `band_hi`=1 the base is 32.5, so the numerator is `1064960 + 2*(freq_word+offset) + 1`.
- R3: With `ask_mode`=0 and `tx_bit`=0 the offset is 0 (lower FSK tone).
- R4: With `ask_mode`=0 and `tx_bit`=1 the offset is `fsep_word` (upper FSK tone).
- R5: With `ask_mode`=1 the offset is `fsep_word >> 1` (odd values round down), and `tx_bit` has no effect on `div_val` or `carry_out`.
- R6: On each enabled clock edge, a 15-bit accumulator adds the fraction. `carry_out` is registered to 1 exactly when that addition reaches 32768, and `div_val` is registered to the integer part plus `carry_out`.
- R7: Starting from a cleared accumulator, the sum of `div_val` over 32768 enabled cycles with constant inputs equals the numerator exactly.
- R8: A clock edge with `rst_n`=0 clears the accumulator, `div_val` and `carry_out` to zero.
- R9: A clock edge with `en`=0 leaves the accumulator, `div_val` and `carry_out` unchanged.
- R10: A change on any input is reflected in `div_val` after the next clock edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Synthesizer enable; low holds all state |
| freq_word | input | 15 | Channel frequency word |
| fsep_word | input | 8 | FSK separation word |
| band_hi | input | 1 | Band select: 0 gives base 24, 1 gives base 32.5 |
| ask_mode | input | 1 | 1 = on-off keying centre frequency, 0 = two-level FSK |
| tx_bit | input | 1 | Serial transmit data bit |
| div_val | output | 6 | Integer divide value for the current reference cycle |
| carry_out | output | 1 | Accumulator overflow flag for the current cycle |

## Verification
The bench targets odd separation words in keying mode. A design that rounds up or ignores the halving lands one separation step off and miscompares on every carry pattern. It toggles the data bit in both modes. A block that lets the bit through in keying mode shows a stepping carrier, and one that reverses the bit sense swaps the tones. Long constant runs at both bases check the exact 32768-cycle sum, which exposes a dropped half step or a 32.5 base rounded to 32 or 33. Disable and reset windows fall between overflows, so an accumulator that drifts while held shows up as a shifted carry sequence.

// File: rtl/fracn_pkg.sv
// Shared widths for the fractional-N divide sequencer.
// Assumes the fraction is held in 15 bits (reference / 32768 units).
package fracn_pkg;
    localparam int FREQ_W_DEF = 15;
    localparam int SEP_W_DEF  = 8;
    localparam int FRAC_W_DEF = 15;
    localparam int NUM_W_DEF  = 21;
endpackage

// File: rtl/fracn_target.sv
// Builds the exact numerator (over 2**FRAC_W) of the wanted divide ratio.
// Assumes FRAC_W >= 2 and that NUM_W holds 32.5*2**FRAC_W plus twice the
// largest word sum. Purely combinational.
module fracn_target #(
    parameter int FREQ_W = 15,
    parameter int SEP_W  = 8,
    parameter int FRAC_W = 15,
    parameter int NUM_W  = 21
) (
    input  logic [FREQ_W-1:0] freq_word,
    input  logic [SEP_W-1:0]  fsep_word,
    input  logic              band_hi,
    input  logic              ask_mode,
    input  logic              tx_bit,
    output logic [NUM_W-1:0]  numer
);
    // 24 = 48/2 and 32.5 = 65/2, both scaled by 2**FRAC_W
    localparam logic [NUM_W-1:0] BASE_LO = NUM_W'(48) << (FRAC_W - 1);
    localparam logic [NUM_W-1:0] BASE_HI = NUM_W'(65) << (FRAC_W - 1);

    logic [SEP_W-1:0] offset;

    // Offset select: keying centre, upper tone or lower tone
    always_comb begin
        if (ask_mode)
            offset = fsep_word >> 1;
        else if (tx_bit)
            offset = fsep_word;
        else
            offset = '0;
    end

    // Numerator: base + 2*(word + offset) + 1 (the +1 is the half step)
    always_comb begin
        numer = (band_hi ? BASE_HI : BASE_LO)
              + (NUM_W'(freq_word) << 1)
              + (NUM_W'(offset) << 1)
              + NUM_W'(1);
    end
endmodule

// File: rtl/fracn_phase_acc.sv
// First-order phase accumulator: adds the fraction each enabled cycle and
// flags overflow. Assumes frac_in < 2**FRAC_W. Synchronous active-low reset.
module fracn_phase_acc #(
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [FRAC_W-1:0] frac_in,
    output logic              carry,
    output logic [FRAC_W-1:0] acc_q
);
    logic [FRAC_W:0] sum;

    // Next phase and overflow
    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, frac_in};
        carry = sum[FRAC_W];
    end

    // Phase register: cleared by reset, held when disabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (en)
            acc_q <= sum[FRAC_W-1:0];
    end

    // R6
    wrap_drops_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && carry) |=> (acc_q < $past(acc_q)));
    // R6
    no_wrap_keeps_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !carry) |=> (acc_q >= $past(acc_q)));
    // R9
    idle_phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_q));
endmodule

// File: rtl/fracn_div_seq.sv
// Top: per-reference-cycle divide value for a fractional-N feedback divider.
// Target numerator from fracn_target, dithering from fracn_phase_acc; the
// outputs are registered, so an input change shows after one clock edge.
module fracn_div_seq
    import fracn_pkg::*;
#(
    parameter int FREQ_W = FREQ_W_DEF,
    parameter int SEP_W  = SEP_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF,
    parameter int NUM_W  = NUM_W_DEF,
    localparam int DIV_W = NUM_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [FREQ_W-1:0] freq_word,
    input  logic [SEP_W-1:0]  fsep_word,
    input  logic              band_hi,
    input  logic              ask_mode,
    input  logic              tx_bit,
    output logic [DIV_W-1:0]  div_val,
    output logic              carry_out
);
    logic [NUM_W-1:0]  numer;
    logic              acc_carry;
    logic [FRAC_W-1:0] acc_q;
    logic [DIV_W-1:0]  int_part;

    fracn_target #(
        .FREQ_W(FREQ_W), .SEP_W(SEP_W), .FRAC_W(FRAC_W), .NUM_W(NUM_W)
    ) u_target (
        .freq_word(freq_word),
        .fsep_word(fsep_word),
        .band_hi  (band_hi),
        .ask_mode (ask_mode),
        .tx_bit   (tx_bit),
        .numer    (numer)
    );

    fracn_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .frac_in(numer[FRAC_W-1:0]),
        .carry  (acc_carry),
        .acc_q  (acc_q)
    );

    // Integer part of the target ratio
    always_comb int_part = numer[NUM_W-1:FRAC_W];

    // Output register: integer part plus dither carry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_val   <= '0;
            carry_out <= 1'b0;
        end else if (en) begin
            div_val   <= int_part + DIV_W'(acc_carry);
            carry_out <= acc_carry;
        end
    end

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (div_val == '0 && !carry_out));
    // R9
    idle_output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(div_val) && $stable(carry_out)));
    // R5
    ask_ignores_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ask_mode && $past(ask_mode) && $stable(freq_word) && $stable(fsep_word)
         && $stable(band_hi)) |-> $stable(numer));
    // R1
    half_step_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> numer[0]);
endmodule

// File: tb/fracn_div_seq_test.sv
`timescale 1ns/1ps
module fracn_div_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [14:0] freq_word = '0;
    logic [7:0]  fsep_word = '0;
    logic        band_hi = 1'b0;
    logic        ask_mode = 1'b0;
    logic        tx_bit = 1'b0;
    logic [5:0]  div_val;
    logic        carry_out;

    int vectors = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    string tag = "R8";

    // behavioural model state
    int m_acc = 0;
    int m_div = 0;
    int m_c = 0;

    always #2.5 clk = ~clk;

    fracn_div_seq uut (
        .clk(clk), .rst_n(rst_n), .en(en), .freq_word(freq_word),
        .fsep_word(fsep_word), .band_hi(band_hi), .ask_mode(ask_mode),
        .tx_bit(tx_bit), .div_val(div_val), .carry_out(carry_out)
    );

    function automatic int target_numer();
        int off;
        if (ask_mode) off = int'(fsep_word) / 2;
        else if (tx_bit) off = int'(fsep_word);
        else off = 0;
        return (band_hi ? 1064960 : 786432) + 2 * (int'(freq_word) + off) + 1;
    endfunction

    // One clock: model updates at the edge, compare at the falling edge
    task automatic step();
        int n;
        int s;
        @(posedge clk);
        n = target_numer();
        if (!rst_n) begin
            m_acc = 0; m_div = 0; m_c = 0;
        end else if (en) begin
            s = m_acc + (n % 32768);
            m_c = (s >= 32768) ? 1 : 0;
            m_acc = s % 32768;
            m_div = n / 32768 + m_c;
        end
        @(negedge clk);
        vectors++;
        if (int'(div_val) != m_div || int'(carry_out) != m_c) begin
            errors++;
            $display("FAIL %s: div=%0d carry=%0d expected div=%0d carry=%0d",
                     tag, div_val, carry_out, m_div, m_c);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // R7: sum over 32768 cycles from a cleared accumulator equals numerator
    task automatic sum_check(input string t);
        int total;
        int want;
        tag = "R8";
        rst_n = 1'b0; step(); rst_n = 1'b1; en = 1'b1;
        want = target_numer();
        total = 0;
        tag = t;
        for (int i = 0; i < 32768; i++) begin
            step();
            total += int'(div_val);
        end
        vectors++;
        if (total != want) begin
            errors++;
            $display("FAIL %s: sum=%0d expected %0d", t, total, want);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 190000", cycles);
            finish_up();
        end
    end

    initial begin
        @(negedge clk);
        // R8 reset state
        tag = "R8"; freq_word = 15'd3730; fsep_word = 8'd100;
        run(3);
        rst_n = 1'b1; en = 1'b1;
        // R1 R3 lower band, lower tone
        tag = "R1_R3"; run(200);
        // R4 upper tone
        tag = "R4"; tx_bit = 1'b1; run(200);
        // R10 toggle data every cycle in FSK
        tag = "R10";
        for (int i = 0; i < 100; i++) begin tx_bit = ~tx_bit; step(); end
        // R2 upper band
        tag = "R2"; band_hi = 1'b1; freq_word = 15'd14342; run(200);
        // R5 keying mode with odd separation, data toggling
        tag = "R5"; ask_mode = 1'b1; fsep_word = 8'd255;
        for (int i = 0; i < 150; i++) begin tx_bit = i[0]; step(); end
        fsep_word = 8'd1;
        for (int i = 0; i < 150; i++) begin tx_bit = i[1]; step(); end
        // R9 enable gaps
        tag = "R9"; ask_mode = 1'b0; freq_word = 15'd22000; fsep_word = 8'd37;
        for (int i = 0; i < 300; i++) begin en = (i % 5) != 2; tx_bit = i[2]; step(); end
        en = 1'b1;
        // R6 varied words
        tag = "R6";
        for (int i = 0; i < 60; i++) begin
            freq_word = 15'(2500 + i * 331);
            fsep_word = 8'(i * 17 + 1);
            band_hi = i[0]; ask_mode = i[1]; tx_bit = i[2];
            run(20);
        end
        // R8 mid-run reset
        tag = "R8"; rst_n = 1'b0; run(2); rst_n = 1'b1; tag = "R6"; run(50);
        // R7 exact average at both bases
        band_hi = 1'b0; ask_mode = 1'b1; freq_word = 15'd3730; fsep_word = 8'd100;
        sum_check("R7_lo");
        band_hi = 1'b1; ask_mode = 1'b0; tx_bit = 1'b1; freq_word = 15'd14342;
        fsep_word = 8'd99;
        sum_check("R7_hi");
        finish_up();
    end
endmodule